// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master that moves one byte at a time. A processor drives it through three byte-wide registers: control, status and data. A write to the data register while the block is enabled starts an 8-bit exchange. The byte goes out most significant bit first. At the same time the byte on the input line is shifted in. The serial clock runs at a fraction of the system clock, chosen by a 2-bit rate code. A polarity bit and a phase bit set the clock's idle level and which edge samples the data.

When the eighth bit finishes, a completion flag is set in the status register. If interrupts are enabled, the interrupt output goes high. A data write that arrives while a byte is still shifting is dropped, and it sets a collision flag. Flags are cleared with a two-step sequence. A status read records which flags are set at that moment. The next data-register access then clears exactly those flags. The chip-select output goes low for each byte and returns high between bytes.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control and status registers read 0x00, `ssN` is 1, `sck` is 0 and `irq` is 0.
- R2: Control bits [1:0] choose the serial clock divide ratio: 2, 4, 16 or 32 system cycles per bit for codes 0 to 3. One byte lasts 8 times that ratio. Counting from the clock edge that accepts the data write, `ssN` rises and the completion flag is set on exactly that edge.
- R3: Each byte produces 16 `sck` transitions. Control bit [3] sets the idle level of `sck`. The byte written to the data register appears on `mosi` most significant bit first.
- R4: With control bit [2] = 0, `miso` is sampled on the first `sck` edge of each bit. With bit [2] = 1, it is sampled on the second edge. After completion, a data-register read returns the 8 sampled bits, the first one in bit 7.
- R5: `ssN` is 0 for the whole byte and 1 when idle.
- R6: Status bit 7 (complete) is set when the byte ends. `irq` is 1 exactly when that flag is set and control bit 7 (interrupt enable) is 1.
- R7: A data write while a byte is shifting does not change the outgoing byte. It sets status bit 6 (collision).
- R8: A data write while control bit 6 (enable) is 0 starts nothing and changes no flag.
- R9: A status read records the flags set at that moment. The next data-register read, or enabled data write, clears only those flags. A data access with nothing recorded clears nothing. A completion discards the record. Status bits 5:0 read as 0.
- R10: Writes to the status register (address 1) have no effect. Register addresses are: 0 control, 1 status, 2 data.
- R11: Reset during a byte ends it at once and returns every port and register to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register address: 0 control, 1 status, 2 data |
| wrEn | input | 1 | Register write strobe, one cycle |
| rdEn | input | 1 | Register read strobe, one cycle; marks the read for flag clearing |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register (combinational) |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
A bad divider count or event counter shows up first at `ssN`. The select rises one or more system cycles away from the 8-times-ratio edge, and the bench checks the cycle before and the cycle of that edge. A wrong phase selection or a shifted sample register shows as a wrong byte in the data register or on the captured `mosi` stream. This appears as soon as the first transfer in that mode ends. Mistakes in the captured-flag logic stay hidden until the next status read after a data access. So every transfer ends with a read-clear-read sequence.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_HALF = 16;
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  // control register bit positions
  localparam int CTL_IRQ_EN = 7;
  localparam int CTL_ENABLE = 6;
  localparam int CTL_CPOL   = 3;
  localparam int CTL_CPHA   = 2;

  typedef struct packed {
    logic              start;
    logic [BYTE_W-1:0] txByte;
    logic              cpol;
    logic              cpha;
    logic [1:0]        rate;
  } ctrlStrobe_t;

  // system cycles per half serial-clock period
  function automatic logic [CNT_W-1:0] halfCycles(input logic [1:0] rate);
    case (rate)
      2'd0:    halfCycles = CNT_W'(1);
      2'd1:    halfCycles = CNT_W'(2);
      2'd2:    halfCycles = CNT_W'(8);
      default: halfCycles = CNT_W'(MAX_HALF);
    endcase
  endfunction
endpackage

// File: rtl/spiDatapath.sv
module spiDatapath
  import spi_pkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       cs,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ssN,
  output logic              busy,
  output logic              doneStb,
  output logic [BITS-1:0]   rxByte
);
  localparam int EVT_W = $clog2(2 * BITS);
  localparam logic [EVT_W-1:0] LAST_EVT = EVT_W'(2 * BITS - 1);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfLen;
  logic [EVT_W-1:0] evtCnt;
  logic             sckActive;
  logic [BITS-1:0]  txSh;
  logic [BITS-1:0]  rxSh;
  logic             tick, leadEv, trailEv, sampleEv, shiftEv;

  assign halfLen  = halfCycles(cs.rate);
  assign tick     = busy && (divCnt == halfLen - CNT_W'(1));
  assign leadEv   = tick && !sckActive;
  assign trailEv  = tick && sckActive;
  assign sampleEv = cs.cpha ? trailEv : leadEv;
  assign shiftEv  = cs.cpha ? (leadEv && (evtCnt != '0)) : trailEv;
  assign doneStb  = trailEv && (evtCnt == LAST_EVT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      divCnt    <= '0;
      evtCnt    <= '0;
      sckActive <= 1'b0;
      txSh      <= '0;
      rxSh      <= '0;
      rxByte    <= '0;
    end else if (cs.start) begin
      busy      <= 1'b1;
      divCnt    <= '0;
      evtCnt    <= '0;
      sckActive <= 1'b0;
      txSh      <= cs.txByte;
    end else if (busy) begin
      if (tick) begin
        divCnt    <= '0;
        evtCnt    <= evtCnt + EVT_W'(1);
        sckActive <= !sckActive;
        if (sampleEv) rxSh <= {rxSh[BITS-2:0], miso};
        if (shiftEv)  txSh <= {txSh[BITS-2:0], 1'b0};
        if (doneStb) begin
          busy   <= 1'b0;
          rxByte <= cs.cpha ? {rxSh[BITS-2:0], miso} : rxSh;
        end
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  assign sck  = cs.cpol ^ sckActive;
  assign mosi = txSh[BITS-1];
  assign ssN  = !busy;
endmodule

// File: rtl/spiRegs.sv
module spiRegs
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              busy,
  input  logic              doneStb,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrlStrobe_t       cs,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic              flagDone,
  output logic              flagWcol,
  output logic              irq
);
  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  logic       selCtl, selStat, selData;
  logic       dataWrOk, dataAcc;
  logic [1:0] armed;
  logic       nextDone, nextWcol;

  assign selCtl   = (regSel == SEL_CTL);
  assign selStat  = (regSel == SEL_STAT);
  assign selData  = (regSel == SEL_DATA);
  assign dataWrOk = wrEn && selData && ctrlReg[CTL_ENABLE];
  assign dataAcc  = (rdEn && selData) || dataWrOk;

  always_comb begin
    nextDone = flagDone;
    nextWcol = flagWcol;
    if (dataAcc) begin
      if (armed[1]) nextDone = 1'b0;
      if (armed[0]) nextWcol = 1'b0;
    end
    if (dataWrOk && busy) nextWcol = 1'b1;
    if (doneStb)          nextDone = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      flagDone <= 1'b0;
      flagWcol <= 1'b0;
      armed    <= '0;
    end else begin
      if (wrEn && selCtl) ctrlReg <= wrData;
      flagDone <= nextDone;
      flagWcol <= nextWcol;
      if (doneStb || dataAcc)   armed <= '0;
      else if (rdEn && selStat) armed <= {flagDone, flagWcol};
    end
  end

  always_comb begin
    cs.start  = dataWrOk && !busy;
    cs.txByte = wrData;
    cs.cpol   = ctrlReg[CTL_CPOL];
    cs.cpha   = ctrlReg[CTL_CPHA];
    cs.rate   = ctrlReg[1:0];
  end

  always_comb begin
    case (regSel)
      SEL_CTL:  rdData = ctrlReg;
      SEL_STAT: rdData = {flagDone, flagWcol, 6'b0};
      SEL_DATA: rdData = rxByte;
      default:  rdData = '0;
    endcase
  end

  assign irq = flagDone && ctrlReg[CTL_IRQ_EN];
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       ssN,
  output logic       irq
);
  ctrlStrobe_t       cs;
  logic              busy, doneStb;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] ctrlReg;
  logic              flagDone, flagWcol;

  spiRegs u_regs (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .busy(busy), .doneStb(doneStb), .rxByte(rxByte),
    .cs(cs), .rdData(rdData), .ctrlReg(ctrlReg), .flagDone(flagDone),
    .flagWcol(flagWcol), .irq(irq)
  );

  spiDatapath #(.BITS(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .miso(miso), .sck(sck), .mosi(mosi),
    .ssN(ssN), .busy(busy), .doneStb(doneStb), .rxByte(rxByte)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regSel,
  input logic       wrEn,
  input logic       ssN,
  input logic       sck,
  input logic       irq,
  input logic [7:0] ctrlReg,
  input logic       flagDone,
  input logic       flagWcol,
  input logic       busy
);
  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> (sck == ctrlReg[3]));

  // R7
  wcol_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagWcol) |-> $past(wrEn && regSel == 2'd2 && ctrlReg[6] && busy));

  // R8
  ss_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> $past(wrEn && regSel == 2'd2 && ctrlReg[6]));

  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagDone) |-> ($past(!ssN) && ssN));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($rose(flagDone) || $past(wrEn && regSel == 2'd0)));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .ssN(ssN),
  .sck(sck), .irq(irq), .ctrlReg(ctrlReg), .flagDone(flagDone),
  .flagWcol(flagWcol), .busy(busy)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       miso;
  logic       sck, mosi, ssN, irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // slave model state
  bit       xferOn = 0;
  bit       mCpol = 0, mCpha = 0;
  logic [7:0] slv = 8'd0;
  logic [7:0] mosiCap = 8'd0;
  int       idx = 0;
  int       edges = 0;

  always #5 clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .miso(miso), .sck(sck), .mosi(mosi),
    .ssN(ssN), .irq(irq)
  );

  assign miso = (idx < 8) ? slv[7 - idx] : 1'b0;

  always @(negedge ssN) begin
    idx = 0;
    edges = 0;
    mosiCap = 8'd0;
  end

  always @(sck) begin
    if (xferOn) begin
      edges = edges + 1;
      if ((sck != mCpol) != mCpha) begin
        mosiCap = {mosiCap[6:0], mosi};
        idx = idx + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    regSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    regSel = s; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && !ssN; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ssN == 1'b1, "R1 ssN", ssN, 1);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);

    // R8 data write while disabled is ignored
    wr(2'd0, 8'h80);
    wr(2'd2, 8'h5A);
    repeat (20) @(negedge clk);
    chk(ssN == 1'b1, "R8 no start", ssN, 1);
    rd(2'd1, v); chk(v == 8'h00, "R8 flags", v, 0);
    // R10 status write ignored
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk(v == 8'h00, "R10 status write", v, 0);

    // sweep over phase, polarity, rate and data patterns
    for (int ph = 0; ph < 2; ph++)
      for (int po = 0; po < 2; po++)
        for (int rt = 0; rt < 4; rt++)
          for (int p = 0; p < 3; p++) begin
            automatic int div = (rt < 2) ? (2 << rt) : (4 << rt);
            automatic logic [7:0] tx = 8'hA5 ^ 8'(p * 37 + rt * 11 + po * 3 + ph * 90);
            automatic logic [7:0] ctl = 8'h40 | 8'(rt[0] << 7) | 8'(po << 3) | 8'(ph << 2) | 8'(rt);
            mCpol = po[0]; mCpha = ph[0];
            slv = {tx[3:0], ~tx[7:4]} ^ 8'(p * 5);
            wr(2'd0, ctl);
            chk(sck == po[0], "R3 idle level", sck, po);
            xferOn = 1;
            wr(2'd2, tx);
            repeat (8 * div - 1) @(negedge clk);
            chk(ssN == 1'b0, "R5 select low in byte", ssN, 0);
            chk(irq == 1'b0, "R6 no early irq", irq, 0);
            @(negedge clk);
            chk(ssN == 1'b1, "R2 byte length", ssN, 1);
            chk(irq == rt[0], "R6 irq gating", irq, rt[0]);
            xferOn = 0;
            chk(edges == 16, "R3 edge count", edges, 16);
            chk(mosiCap == tx, "R3 mosi order", mosiCap, tx);
            rd(2'd1, v); chk(v == 8'h80, "R6 complete flag", v, 8'h80);
            rd(2'd2, v); chk(v == slv, "R4 received byte", v, slv);
            rd(2'd1, v); chk(v == 8'h00, "R9 flags cleared", v, 0);
            chk(irq == 1'b0, "R6 irq cleared", irq, 0);
          end

    // R7 and R9 collision sequence
    mCpol = 0; mCpha = 0; slv = 8'h96;
    wr(2'd0, 8'h40);
    xferOn = 1;
    wr(2'd2, 8'h3C);
    wr(2'd2, 8'hFF);
    rd(2'd1, v); chk(v == 8'h40, "R7 collision flag", v, 8'h40);
    waitIdle();
    xferOn = 0;
    chk(mosiCap == 8'h3C, "R7 byte unchanged", mosiCap, 8'h3C);
    rd(2'd2, v); chk(v == 8'h96, "R4 received byte", v, 8'h96);
    rd(2'd1, v); chk(v == 8'hC0, "R9 no clear after completion", v, 8'hC0);
    rd(2'd2, v);
    rd(2'd1, v); chk(v == 8'h00, "R9 captured clear", v, 0);

    // R9 only recorded flags clear: record none, then set done, then data read
    wr(2'd0, 8'h40);
    rd(2'd1, v);
    xferOn = 1;
    wr(2'd2, 8'h11);
    waitIdle();
    xferOn = 0;
    rd(2'd2, v);
    rd(2'd1, v); chk(v == 8'h80, "R9 unrecorded flag kept", v, 8'h80);
    rd(2'd2, v);
    rd(2'd1, v); chk(v == 8'h00, "R9 second clear", v, 0);

    // R11 reset mid-byte
    wr(2'd0, 8'hCB);
    wr(2'd2, 8'h77);
    repeat (10) @(negedge clk);
    chk(ssN == 1'b0, "R11 busy before reset", ssN, 0);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk(ssN == 1'b1, "R11 ssN", ssN, 1);
    chk(sck == 1'b0, "R11 sck", sck, 0);
    rd(2'd0, v); chk(v == 8'h00, "R11 ctrl", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R11 status", v, 0);
    repeat (600) @(negedge clk);
    chk(ssN == 1'b1, "R11 stays idle", ssN, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule